// File: doc/BRIEF.md
# Supply Fail Supervisor and Write Guard

This block supervises a battery-backed memory array from inside a clocked domain. Two digital flags arrive from external comparators. One says the supply is above the write-protect trip point. The other says the supply is above the lower level at which the array may stay on the main rail. Both flags are asynchronous, so each passes through a synchronizer and a debounce filter before the block acts on it.

From the filtered trip flag the block derives two power-up holdoffs. Write protection lifts first. The reset request releases later. A supply dip during either holdoff starts both holdoffs again from zero. While protection is in force, the block drives the memory's chip, write and output enables inactive, whatever the host drives, and it keeps the data drivers off.

The filtered switchover flag chooses the source that powers the array. The reset output is an open-drain enable: a 1 means pull the line low, and the block never drives the line high. Every interval is a parameter counted in clock cycles. Elaboration rejects any configuration that breaks the ordering of the holdoffs or the fail-to-protect latency budget.

Top module: `supply_guard`

## Requirements
- R1: Each comparator flag is synchronized through SYNC_STAGES flip-flops and then debounced. The filtered level changes only after the synchronized flag has differed from it for DEBOUNCE_CYC consecutive cycles. A raw pulse shorter than DEBOUNCE_CYC cycles changes no output.
- R2: A fall of the raw trip flag asserts both `wr_protect` and `rst_pull_low` exactly SYNC_STAGES+DEBOUNCE_CYC clock edges later. That count must not exceed FAIL_LIMIT_CYC.
- R3: While `wr_protect` is 1, `mem_ce_n`, `mem_we_n` and `mem_oe_n` are 1 and `dq_drive` is 0, for any host input.
- R4: While `wr_protect` is 0, each `mem_*_n` equals the matching `host_*_n`. `dq_drive` is 1 exactly when chip enable and output enable are low and write enable is high.
- R5: After the raw trip flag rises and stays high, `wr_protect` falls SYNC_STAGES+DEBOUNCE_CYC+WP_HOLD_CYC edges after the rise.
- R6: `rst_pull_low` falls SYNC_STAGES+DEBOUNCE_CYC+RST_HOLD_CYC edges after the rise. RST_HOLD_CYC must exceed WP_HOLD_CYC, and `rst_pull_low` is 1 whenever `wr_protect` is 1.
- R7: A filtered trip drop during either holdoff restarts both holdoffs from zero, counted from the next filtered rise.
- R8: `bat_select` is 1 (array on battery) while the filtered switchover flag is low and 0 while it is high. Its timing follows R1 and does not depend on the trip flag.
- R9: During and immediately after reset, `rst_pull_low`, `wr_protect` and `bat_select` are all 1. The supply is treated as absent until the filters see it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Supervisor clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trip_ok_raw | input | 1 | Comparator flag: supply above write-protect trip point |
| swover_ok_raw | input | 1 | Comparator flag: supply above battery switchover level |
| host_ce_n | input | 1 | Host chip enable, active low |
| host_we_n | input | 1 | Host write enable, active low |
| host_oe_n | input | 1 | Host output enable, active low |
| mem_ce_n | output | 1 | Gated chip enable to the array |
| mem_we_n | output | 1 | Gated write enable to the array |
| mem_oe_n | output | 1 | Gated output enable to the array |
| dq_drive | output | 1 | Data bus driver enable (0 = high impedance) |
| wr_protect | output | 1 | Write protection in force |
| rst_pull_low | output | 1 | Open-drain reset enable, 1 = pull low |
| bat_select | output | 1 | Array power source, 1 = battery |

## Verification
The bench drives the trip flag with pulses one cycle shorter than the debounce window. A filter that let a short pulse through would show up as an early release of protection. It measures each latency in clock edges, from the raw rise or fall to the output change. An off-by-one in the synchronizer depth, the debounce count or a holdoff compare would land one edge away from the expected figure. It drops the supply twice: once inside the write holdoff, and once after write protection has lifted but before reset has released. A design that resumed a partly elapsed count would therefore release reset too early. Random host strobes run alongside all of this, and any enable leaking through while protection is in force is caught.

// File: rtl/supply_guard_pkg.sv
package supply_guard_pkg;
   localparam int FLAG_TRIP   = 0;
   localparam int FLAG_SWOVER = 1;
   localparam int NUM_FLAGS   = 2;

   typedef struct packed {
      logic swover_ok;
      logic trip_ok;
   } supply_flags_t;
endpackage

// File: rtl/supply_flag_filter.sv
module supply_flag_filter #(
   parameter int SYNC_STAGES  = 2,
   parameter int DEBOUNCE_CYC = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw_i,
   output logic clean_o
);
   localparam int CW = $clog2(DEBOUNCE_CYC + 1);

   logic [SYNC_STAGES-1:0] sync_q;
   logic [CW-1:0]          run_q;
   logic                   level_q;
   logic                   synced;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("supply_flag_filter: SYNC_STAGES must be at least 2");
      end
      if (DEBOUNCE_CYC < 1) begin : g_bad_deb
         $error("supply_flag_filter: DEBOUNCE_CYC must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '0;
      else        sync_q <= {sync_q[SYNC_STAGES-2:0], raw_i};
   end

   assign synced = sync_q[SYNC_STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q   <= '0;
         level_q <= 1'b0;
      end else if (synced != level_q) begin
         if (run_q == CW'(DEBOUNCE_CYC - 1)) begin
            level_q <= synced;
            run_q   <= '0;
         end else begin
            run_q <= run_q + 1'b1;
         end
      end else begin
         run_q <= '0;
      end
   end

   assign clean_o = level_q;

   // R1: the filtered level moves only at the end of a full mismatch run
   assert_debounce_run_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (level_q != $past(level_q)) |-> ($past(run_q) == CW'(DEBOUNCE_CYC - 1)));
endmodule

// File: rtl/supply_holdoff_seq.sv
module supply_holdoff_seq #(
   parameter int WP_HOLD_CYC  = 125000,
   parameter int RST_HOLD_CYC = 200000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ok_i,
   output logic wp_o,
   output logic rst_o
);
   localparam int CW = $clog2(RST_HOLD_CYC + 1);

   logic [CW-1:0] since_q;

   generate
      if (RST_HOLD_CYC <= WP_HOLD_CYC) begin : g_bad_order
         $error("supply_holdoff_seq: reset holdoff must exceed write holdoff");
      end
      if (WP_HOLD_CYC < 1) begin : g_bad_wp
         $error("supply_holdoff_seq: WP_HOLD_CYC must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          since_q <= '0;
      else if (!ok_i)                      since_q <= '0;
      else if (since_q != CW'(RST_HOLD_CYC)) since_q <= since_q + 1'b1;
   end

   assign wp_o  = !ok_i || (since_q < CW'(WP_HOLD_CYC));
   assign rst_o = !ok_i || (since_q < CW'(RST_HOLD_CYC));

   // R6: reset always covers write protection
   assert_rst_covers_wp_R6: assert property (@(posedge clk) disable iff (!rst_n)
      wp_o |-> rst_o);

   // R5: protection lifts only with the supply good and the write holdoff done
   assert_wp_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!wp_o && $past(wp_o)) |-> (ok_i && since_q == CW'(WP_HOLD_CYC)));

   // R7: a new rise of the supply flag always starts from zero elapsed time
   assert_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ok_i && !$past(ok_i)) |-> (since_q == '0));
endmodule

// File: rtl/supply_guard.sv
module supply_guard
   import supply_guard_pkg::*;
#(
   parameter int SYNC_STAGES   = 2,
   parameter int DEBOUNCE_CYC  = 4,
   parameter int FAIL_LIMIT_CYC = 8,
   parameter int WP_HOLD_CYC   = 125000,
   parameter int RST_HOLD_CYC  = 200000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic trip_ok_raw,
   input  logic swover_ok_raw,
   input  logic host_ce_n,
   input  logic host_we_n,
   input  logic host_oe_n,
   output logic mem_ce_n,
   output logic mem_we_n,
   output logic mem_oe_n,
   output logic dq_drive,
   output logic wr_protect,
   output logic rst_pull_low,
   output logic bat_select
);
   localparam int FAIL_LATENCY = SYNC_STAGES + DEBOUNCE_CYC;

   logic [NUM_FLAGS-1:0] raw_vec;
   logic [NUM_FLAGS-1:0] clean_vec;
   supply_flags_t        flags;

   generate
      if (FAIL_LATENCY > FAIL_LIMIT_CYC) begin : g_bad_latency
         $error("supply_guard: filter latency exceeds the fail budget");
      end
   endgenerate

   assign raw_vec[FLAG_TRIP]   = trip_ok_raw;
   assign raw_vec[FLAG_SWOVER] = swover_ok_raw;

   generate
      for (genvar f = 0; f < NUM_FLAGS; f++) begin : g_flag
         supply_flag_filter #(
            .SYNC_STAGES (SYNC_STAGES),
            .DEBOUNCE_CYC(DEBOUNCE_CYC)
         ) i_filter (
            .clk    (clk),
            .rst_n  (rst_n),
            .raw_i  (raw_vec[f]),
            .clean_o(clean_vec[f])
         );
      end
   endgenerate

   assign flags.trip_ok   = clean_vec[FLAG_TRIP];
   assign flags.swover_ok = clean_vec[FLAG_SWOVER];

   supply_holdoff_seq #(
      .WP_HOLD_CYC (WP_HOLD_CYC),
      .RST_HOLD_CYC(RST_HOLD_CYC)
   ) i_holdoff (
      .clk  (clk),
      .rst_n(rst_n),
      .ok_i (flags.trip_ok),
      .wp_o (wr_protect),
      .rst_o(rst_pull_low)
   );

   assign bat_select = !flags.swover_ok;

   assign mem_ce_n = host_ce_n | wr_protect;
   assign mem_we_n = host_we_n | wr_protect;
   assign mem_oe_n = host_oe_n | wr_protect;
   assign dq_drive = !wr_protect && !host_ce_n && !host_oe_n && host_we_n;

   // R3: nothing reaches the array while protected
   assert_gate_closed_R3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_protect |-> (mem_ce_n && mem_we_n && mem_oe_n && !dq_drive));

   // R2: a filtered trip loss puts protection and reset in force at once
   assert_fail_protects_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!flags.trip_ok && $past(flags.trip_ok)) |-> (wr_protect && rst_pull_low));
endmodule

// File: tb/test_supply_guard.sv
module test_supply_guard;
   localparam int CLK_PERIOD = 10;
   localparam int SYNC = 2;
   localparam int DEB  = 3;
   localparam int WPH  = 20;
   localparam int RSTH = 32;
   localparam int LIM  = 8;

   logic clk = 0, rst_n = 0;
   logic trip_raw = 0, sw_raw = 0;
   logic hce = 1, hwe = 1, hoe = 1;
   logic mce, mwe, moe, dqd, wp, rpl, bat;

   int vectors = 0, fails = 0;
   bit model_on = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   supply_guard #(.SYNC_STAGES(SYNC), .DEBOUNCE_CYC(DEB), .FAIL_LIMIT_CYC(LIM),
                  .WP_HOLD_CYC(WPH), .RST_HOLD_CYC(RSTH)) i_supply_guard (
      .clk(clk), .rst_n(rst_n), .trip_ok_raw(trip_raw), .swover_ok_raw(sw_raw),
      .host_ce_n(hce), .host_we_n(hwe), .host_oe_n(hoe),
      .mem_ce_n(mce), .mem_we_n(mwe), .mem_oe_n(moe), .dq_drive(dqd),
      .wr_protect(wp), .rst_pull_low(rpl), .bat_select(bat));

   // behavioural reference: raw history queues and elapsed-time counter
   bit hist_t[$], hist_s[$];
   bit m_trip, m_sw;
   int m_since;

   function automatic bit run_done(ref bit h[$], input bit lvl);
      for (int k = SYNC; k < SYNC + DEB; k++) if (h[k] == lvl) return 0;
      return 1;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hist_t = {}; hist_s = {};
         for (int k = 0; k < SYNC + DEB; k++) begin hist_t.push_back(0); hist_s.push_back(0); end
         m_trip = 0; m_sw = 0; m_since = 0;
      end else begin
         hist_t.push_front(trip_raw); void'(hist_t.pop_back());
         hist_s.push_front(sw_raw);   void'(hist_s.pop_back());
         m_since = m_trip ? ((m_since < RSTH) ? m_since + 1 : RSTH) : 0;
         if (run_done(hist_t, m_trip)) m_trip = !m_trip;
         if (run_done(hist_s, m_sw))   m_sw = !m_sw;
      end
   end

   task automatic check(input string req, input string what, input int act, input int exp);
      vectors++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) if (model_on) begin
      bit ewp;
      ewp = !m_trip || (m_since < WPH);
      check("R5", "wr_protect vs model", wp, ewp);
      check("R6", "rst_pull_low vs model", rpl, !m_trip || (m_since < RSTH));
      check("R8", "bat_select vs model", bat, !m_sw);
      if (ewp) check("R3", "gated strobes", {mce, mwe, moe, dqd}, 4'b1110);
      else     check("R4", "pass strobes", {mce, mwe, moe, dqd},
                     {hce, hwe, hoe, (!hce && !hoe && hwe)});
   end

   task automatic step(); @(posedge clk); #(CLK_PERIOD/4); endtask

   // edges from now until the selected output reaches val
   task automatic edges_until(input int sel, input logic val, output int n);
      logic cur;
      n = 0;
      do begin
         @(posedge clk); n++; @(negedge clk);
         cur = (sel == 0) ? wp : (sel == 1) ? rpl : bat;
      end while (cur !== val && n < 500);
      #(CLK_PERIOD/4);
   endtask

   always @(posedge clk) if (model_on) begin
      #(CLK_PERIOD/4);
      hce = $urandom_range(0, 1); hwe = $urandom_range(0, 1); hoe = $urandom_range(0, 1);
   end

   initial begin
      #(CLK_PERIOD * 50000);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      int n;
      hce = 0; hwe = 0; hoe = 0;
      #(CLK_PERIOD * 3);
      // R9: reset state, strobes closed (R3)
      check("R9", "reset rst_pull_low", rpl, 1);
      check("R9", "reset wr_protect", wp, 1);
      check("R9", "reset bat_select", bat, 1);
      check("R3", "reset strobes", {mce, mwe, moe, dqd}, 4'b1110);
      @(negedge clk); rst_n = 1; model_on = 1;
      step();
      check("R9", "after reset wr_protect", wp, 1);

      // R1: short pulse on both flags is rejected
      trip_raw = 1; sw_raw = 1;
      repeat (DEB - 1) step();
      trip_raw = 0; sw_raw = 0;
      repeat (SYNC + DEB + 4) step();
      check("R1", "short pulse bat_select", bat, 1);
      check("R1", "short pulse rst_pull_low", rpl, 1);

      // R8: switchover flag alone
      sw_raw = 1;
      edges_until(2, 0, n);
      check("R8", "battery release edges", n, SYNC + DEB);
      check("R8", "protect unaffected by switchover", wp, 1);

      // R5/R6: clean power-up
      trip_raw = 1;
      edges_until(0, 0, n);
      check("R5", "write holdoff edges", n, SYNC + DEB + WPH);
      edges_until(1, 0, n);
      check("R6", "reset holdoff edges", n, RSTH - WPH);

      // R2: fail latency
      trip_raw = 0;
      edges_until(0, 1, n);
      check("R2", "fail to protect edges", n, SYNC + DEB);
      check("R2", "reset with protect", rpl, 1);
      check("R2", "within budget", (n <= LIM), 1);

      // R7: dip inside write holdoff
      trip_raw = 1;
      repeat (SYNC + DEB + WPH / 2) step();
      trip_raw = 0;
      repeat (SYNC + DEB + 2) step();
      trip_raw = 1;
      edges_until(0, 0, n);
      check("R7", "write holdoff restart", n, SYNC + DEB + WPH);
      // R7: dip after write release, before reset release
      repeat (2) step();
      trip_raw = 0;
      repeat (SYNC + DEB + 2) step();
      check("R7", "dip reprotects", wp, 1);
      trip_raw = 1;
      edges_until(1, 0, n);
      check("R7", "reset holdoff restart", n, SYNC + DEB + RSTH);

      // R8: switchover drop while trip flag stays high
      sw_raw = 0;
      edges_until(2, 1, n);
      check("R8", "battery select edges", n, SYNC + DEB);
      check("R8", "protect unaffected", wp, 0);

      // R4: pass-through with steady patterns
      model_on = 0;
      #(CLK_PERIOD / 2);
      for (int p = 0; p < 8; p++) begin
         {hce, hwe, hoe} = 3'(p);
         #1;
         check("R4", "pass-through", {mce, mwe, moe, dqd},
               {hce, hwe, hoe, (!hce && !hoe && hwe)});
      end
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end
endmodule